// File: doc/BRIEF.md
# Blank-Check and Erase-Retry Sequencer

This block readies a pair of on-chip nonvolatile arrays for a later programming stage. On a start request it reads every location of a one-time-programmable array in ascending order and requires each byte to hold the unprogrammed value 0x00. The first nonzero byte lights the red indicator and stops the sequencer for good. A clean sweep lights the green indicator.

Next the sequencer holds on a level-sensitive erase enable input. Once that input is high it drives an erase request for a fixed number of cycles, then reads the whole electrically erasable array back. Every byte there must be 0xFF. A single bad byte lights the red indicator and starts another erase pulse. The loop repeats with no limit until one read-back pass is clean. At that point the red indicator goes out, the security bit output is cleared and a ready output is raised.

Both arrays use a synchronous read port: the address and read strobe are driven in one cycle, and the data byte is sampled in the following cycle. Array depths and the erase pulse length are parameters. The default pulse is 400,000 cycles, which is 100 ms at 4 MHz.

Top module: `blank_erase_seq`

## Requirements
- R1: While rst_ni is low and after reset, the block is idle. Both indicators are off, secure_o is 1, ready_o, fail_o and erase_o are 0, and neither read strobe is active.
- R2: A start_i level seen in the idle state starts the first sweep. otp_rd_o is high with otp_addr_o equal to 0 in the first cycle after that edge. The address then rises by one each cycle up to OTP_DEPTH-1. The byte for each address is compared one cycle after its read.
- R3: If any byte of the first array is not 0x00, the red indicator and fail_o go high in the cycle after that byte is compared, and they stay high. After that there is no erase request and no further read.
- R4: When all OTP_DEPTH bytes read 0x00, the green indicator turns on in the cycle after the last compare and stays on.
- R5: After a clean first sweep, the block makes no erase request while erase_en_i is low. The first erase cycle follows the first edge at which erase_en_i is seen high.
- R6: Each erase pulse holds erase_o high for exactly ERASE_CYCLES consecutive cycles. No read strobe is active during the pulse.
- R7: After each pulse, the second array is read at addresses 0 to EE_DEPTH-1 with the same timing as R2. A byte other than 0xFF turns the red indicator on and starts a new erase pulse in the next cycle.
- R8: A read-back pass that finds every byte at 0xFF turns the red indicator off, clears secure_o and raises ready_o. These outputs then hold.
- R9: start_i has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the sequence from idle |
| erase_en_i | input | 1 | Level gate for erasing |
| otp_addr_o | output | OTP_AW | First array read address |
| otp_rd_o | output | 1 | First array read strobe |
| otp_data_i | input | 8 | First array data, one cycle after the strobe |
| ee_addr_o | output | EE_AW | Second array read address |
| ee_rd_o | output | 1 | Second array read strobe |
| ee_data_i | input | 8 | Second array data, one cycle after the strobe |
| erase_o | output | 1 | Erase request to the second array |
| led_red_o | output | 1 | Error indicator |
| led_green_o | output | 1 | First array blank indicator |
| secure_o | output | 1 | Security bit, cleared on success |
| ready_o | output | 1 | Both arrays prepared |
| fail_o | output | 1 | Halted on a programmed first-array byte |

## Verification
The compare of the final read-back byte can land in the same cycle as the sweep's read of a further address. At that edge the block must choose between finishing the pass and starting a new erase pulse. The bench provokes this by leaving only the last address of the second array unerased for one extra pulse, and it does the same for the first array's last byte. A behavioural reference model runs every cycle and checks that the red indicator rises and the next pulse begins on exactly the predicted edge, with no ready pulse in between.

// File: rtl/blank_erase_pkg.sv
package blank_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_WAIT_EN,
    ST_ERASE,
    ST_VERIFY,
    ST_READY,
    ST_FAIL
  } seq_state_e;

  localparam logic [7:0] OTP_BLANK = 8'h00;
  localparam logic [7:0] EE_BLANK  = 8'hFF;
endpackage

// File: rtl/bes_sweep.sv
module bes_sweep #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter logic [7:0]  EXP   = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  input  logic [7:0]    data_i,
  output logic          bad_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          issued_all_q;
  logic          pend_q;
  logic          pend_last_q;

  assign rd_o   = en_i & ~issued_all_q;
  assign addr_o = addr_q;
  // data for the previous strobe is on data_i now
  assign bad_o  = en_i & pend_q & (data_i != EXP);
  assign done_o = en_i & pend_q & pend_last_q & (data_i == EXP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      issued_all_q <= 1'b0;
      pend_q       <= 1'b0;
      pend_last_q  <= 1'b0;
    end else if (!en_i) begin
      addr_q       <= '0;
      issued_all_q <= 1'b0;
      pend_q       <= 1'b0;
      pend_last_q  <= 1'b0;
    end else begin
      pend_q      <= rd_o;
      pend_last_q <= rd_o && (addr_q == LAST);
      if (rd_o) begin
        if (addr_q == LAST) issued_all_q <= 1'b1;
        else                addr_q       <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bes_erase_timer.sv
module bes_erase_timer #(
  parameter int unsigned ERASE_CYCLES = 400000,
  parameter int unsigned CW           = $clog2(ERASE_CYCLES) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);
  localparam logic [CW-1:0] TERM = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = en_i & (cnt_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/blank_erase_seq.sv
module blank_erase_seq
  import blank_erase_pkg::*;
#(
  parameter int unsigned OTP_DEPTH    = 16384,
  parameter int unsigned EE_DEPTH     = 256,
  parameter int unsigned ERASE_CYCLES = 400000,
  parameter int unsigned OTP_AW       = $clog2(OTP_DEPTH),
  parameter int unsigned EE_AW        = $clog2(EE_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_en_i,
  output logic [OTP_AW-1:0] otp_addr_o,
  output logic              otp_rd_o,
  input  logic [7:0]        otp_data_i,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic              ee_rd_o,
  input  logic [7:0]        ee_data_i,
  output logic              erase_o,
  output logic              led_red_o,
  output logic              led_green_o,
  output logic              secure_o,
  output logic              ready_o,
  output logic              fail_o
);
  seq_state_e state_q, state_d;
  logic otp_bad, otp_done, ee_bad, ee_done, tmr_done;
  logic red_q, green_q, sec_q;

  bes_sweep #(.DEPTH(OTP_DEPTH), .AW(OTP_AW), .EXP(OTP_BLANK)) u_otp_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_BLANK),
    .addr_o (otp_addr_o),
    .rd_o   (otp_rd_o),
    .data_i (otp_data_i),
    .bad_o  (otp_bad),
    .done_o (otp_done)
  );

  bes_sweep #(.DEPTH(EE_DEPTH), .AW(EE_AW), .EXP(EE_BLANK)) u_ee_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_VERIFY),
    .addr_o (ee_addr_o),
    .rd_o   (ee_rd_o),
    .data_i (ee_data_i),
    .bad_o  (ee_bad),
    .done_o (ee_done)
  );

  bes_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ST_ERASE),
    .expired_o (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_BLANK;
      ST_BLANK: begin
        if (otp_bad)       state_d = ST_FAIL;
        else if (otp_done) state_d = ST_WAIT_EN;
      end
      ST_WAIT_EN: if (erase_en_i) state_d = ST_ERASE;
      ST_ERASE:   if (tmr_done)   state_d = ST_VERIFY;
      ST_VERIFY: begin
        if (ee_bad)       state_d = ST_ERASE;  // retry without limit
        else if (ee_done) state_d = ST_READY;
      end
      ST_READY:   state_d = ST_READY;
      ST_FAIL:    state_d = ST_FAIL;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      red_q   <= 1'b0;
      green_q <= 1'b0;
      sec_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_q == ST_BLANK) begin
        if (otp_bad)       red_q   <= 1'b1;
        else if (otp_done) green_q <= 1'b1;
      end
      if (state_q == ST_VERIFY) begin
        if (ee_bad) red_q <= 1'b1;
        else if (ee_done) begin
          red_q <= 1'b0;
          sec_q <= 1'b0;
        end
      end
    end
  end

  assign erase_o     = (state_q == ST_ERASE);
  assign ready_o     = (state_q == ST_READY);
  assign fail_o      = (state_q == ST_FAIL);
  assign led_red_o   = red_q;
  assign led_green_o = green_q;
  assign secure_o    = sec_q;
endmodule

// File: rtl/blank_erase_seq_chk.sv
module blank_erase_seq_chk #(
  parameter int unsigned ERASE_CYCLES = 400000,
  parameter int unsigned OTP_AW       = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OTP_AW-1:0] otp_addr_o,
  input logic              otp_rd_o,
  input logic              ee_rd_o,
  input logic              erase_o,
  input logic              led_red_o,
  input logic              led_green_o,
  input logic              secure_o,
  input logic              ready_o,
  input logic              fail_o
);
  logic [31:0] erase_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      erase_run_q <= '0;
    else if (erase_o) erase_run_q <= erase_run_q + 1;
    else              erase_run_q <= '0;
  end

  AST_OTP_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (otp_rd_o && $past(otp_rd_o)) |-> (otp_addr_o == $past(otp_addr_o) + OTP_AW'(1))); // R2
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> (fail_o && led_red_o && !erase_o && !otp_rd_o && !ee_rd_o)); // R3
  AST_END_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ready_o, fail_o, erase_o})); // R3
  AST_ERASE_AFTER_GREEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> led_green_o); // R5
  AST_ERASE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (!otp_rd_o && !ee_rd_o)); // R6
  AST_ERASE_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (erase_run_q < ERASE_CYCLES)); // R6
  AST_ERASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(erase_o) |-> (erase_run_q == ERASE_CYCLES)); // R6
  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o && !secure_o && !led_red_o)); // R8
endmodule

bind blank_erase_seq blank_erase_seq_chk #(
  .ERASE_CYCLES (ERASE_CYCLES),
  .OTP_AW       (OTP_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .otp_addr_o  (otp_addr_o),
  .otp_rd_o    (otp_rd_o),
  .ee_rd_o     (ee_rd_o),
  .erase_o     (erase_o),
  .led_red_o   (led_red_o),
  .led_green_o (led_green_o),
  .secure_o    (secure_o),
  .ready_o     (ready_o),
  .fail_o      (fail_o)
);

// File: tb/blank_erase_seq_tb.sv
`timescale 1ns/1ps
module blank_erase_seq_tb;
  localparam int N   = 64;
  localparam int CYC = 50;
  localparam int AW  = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic erase_en_i = 1'b0;
  logic [AW-1:0] otp_addr_o, ee_addr_o;
  logic otp_rd_o, ee_rd_o, erase_o, led_red_o, led_green_o, secure_o, ready_o, fail_o;
  logic [7:0] otp_q = 8'h00;
  logic [7:0] ee_q = 8'h00;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [7:0] otp_mem [N];
  int ee_need [N];
  int n_erase = 0;
  logic er_d = 1'b0;

  always #5 clk_i = ~clk_i;

  blank_erase_seq #(.OTP_DEPTH(N), .EE_DEPTH(N), .ERASE_CYCLES(CYC)) u_dut (
    .clk_i, .rst_ni, .start_i, .erase_en_i,
    .otp_addr_o, .otp_rd_o, .otp_data_i(otp_q),
    .ee_addr_o, .ee_rd_o, .ee_data_i(ee_q),
    .erase_o, .led_red_o, .led_green_o, .secure_o, .ready_o, .fail_o
  );

  // behavioural arrays: an erasable byte reads FF once enough pulses have started
  always @(posedge clk_i) begin
    er_d <= erase_o;
    if (erase_o && !er_d) n_erase <= n_erase + 1;
    if (otp_rd_o) otp_q <= otp_mem[otp_addr_o];
    if (ee_rd_o)  ee_q  <= (n_erase >= ee_need[ee_addr_o]) ? 8'hFF : 8'h5A;
  end

  // reference model: ph 0 idle,1 otp sweep,2 wait,3 erase,4 ee sweep,5 ready,6 fail
  int ph = 0, cnt = 0, ecnt = 0, pidx = 0;
  bit pend = 0, red = 0, green = 0, sec = 1;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ph = 0; cnt = 0; ecnt = 0; pend = 0; red = 0; green = 0; sec = 1;
    end else begin
      case (ph)
        0: if (start_i) begin ph = 1; cnt = 0; pend = 0; end
        1: begin
          if (pend && otp_q != 8'h00) begin ph = 6; red = 1; end
          else if (pend && pidx == N-1) begin ph = 2; green = 1; end
          else begin
            pend = (cnt < N); pidx = cnt;
            if (cnt < N) cnt++;
          end
        end
        2: if (erase_en_i) begin ph = 3; ecnt = 0; end
        3: if (ecnt == CYC-1) begin ph = 4; cnt = 0; pend = 0; end else ecnt++;
        4: begin
          if (pend && ee_q != 8'hFF) begin ph = 3; ecnt = 0; red = 1; end
          else if (pend && pidx == N-1) begin ph = 5; red = 0; sec = 0; end
          else begin
            pend = (cnt < N); pidx = cnt;
            if (cnt < N) cnt++;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cycles, act, exp);
    end
  endtask

  // per-cycle compare away from the active edge
  always @(negedge clk_i) begin
    cycles++;
    chk("R3/R7", "led_red", led_red_o, red);
    chk("R4", "led_green", led_green_o, green);
    chk("R8", "secure", secure_o, sec);
    chk("R8", "ready", ready_o, ph == 5);
    chk("R3", "fail", fail_o, ph == 6);
    chk("R5/R6", "erase", erase_o, ph == 3);
    chk("R2", "otp_rd", otp_rd_o, (ph == 1) && (cnt < N));
    chk("R7", "ee_rd", ee_rd_o, (ph == 4) && (cnt < N));
    if (ph == 1 && cnt < N) chk("R2", "otp_addr", otp_addr_o, cnt);
    if (ph == 4 && cnt < N) chk("R7", "ee_addr", ee_addr_o, cnt);
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic setup(int bad_otp, int need0, int need_last);
    for (int i = 0; i < N; i++) begin
      otp_mem[i] = 8'h00;
      ee_need[i] = 1;
    end
    if (bad_otp >= 0) otp_mem[bad_otp] = 8'h21;
    ee_need[0] = need0;
    ee_need[N-1] = need_last;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; start_i = 1'b0; erase_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    n_erase = 0;
    // R1: idle state after reset
    chk("R1", "idle red", led_red_o, 0);
    chk("R1", "idle secure", secure_o, 1);
    chk("R1", "idle strobes", {otp_rd_o, ee_rd_o, erase_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_until_end(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i);
      if (ready_o || fail_o) break;
    end
  endtask

  initial begin
    // T1: clean first array, one erase suffices
    setup(-1, 1, 1);
    do_reset();
    erase_en_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    run_until_end(2000);
    chk("R8", "ready after one erase", ready_o, 1);
    chk("R6", "pulse count", n_erase, 1);

    // T2: programmed byte mid-array
    setup(5, 1, 1);
    do_reset();
    erase_en_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    run_until_end(500);
    repeat (200) @(negedge clk_i);
    chk("R3", "halted", fail_o, 1);
    chk("R3", "no erase after fail", n_erase, 0);

    // T3: programmed last byte (boundary)
    setup(N-1, 1, 1);
    do_reset();
    erase_en_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    run_until_end(500);
    chk("R3", "fail on last byte", fail_o, 1);
    chk("R4", "green stays off", led_green_o, 0);

    // T4: enable held low, then raised; start pulsed again while busy (R9)
    setup(-1, 1, 1);
    do_reset();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (N + 40) @(negedge clk_i);
    chk("R5", "no erase while gated", n_erase, 0);
    chk("R4", "green on", led_green_o, 1);
    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    start_i = 1'b0;
    chk("R9", "start ignored in wait", erase_o, 0);
    erase_en_i = 1'b1;
    run_until_end(2000);
    chk("R5", "ready after enable", ready_o, 1);

    // T5: stubborn bytes force retries; start held high throughout (R9)
    setup(-1, 3, 2);
    do_reset();
    erase_en_i = 1'b1;
    start_i = 1'b1;
    run_until_end(5000);
    chk("R7", "three pulses", n_erase, 3);
    chk("R8", "ready after retries", ready_o, 1);
    chk("R8", "red cleared", led_red_o, 0);
    repeat (20) @(negedge clk_i);
    chk("R9", "ready holds with start high", ready_o, 1);
    start_i = 1'b0;

    // T6: only last erasable byte lags one pulse
    setup(-1, 1, 2);
    do_reset();
    erase_en_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    run_until_end(5000);
    chk("R7", "last byte retry", n_erase, 2);
    chk("R8", "secure cleared", secure_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule